// File: doc/BRIEF.md
# Overlay Layer Blend Stage

This block composites one foreground layer onto a background pixel stream. A multi-layer picture is built by chaining stages. Stage one draws layer 1 over layer 0. Its output stream is the background of stage two, which draws layer 2, and so on. The output of the last stage is the finished image. Each background pixel arrives with its column and row position. The overlay pixel that belongs at that position is presented on the same cycle. The stage raises `ov_take_o` for every overlay pixel it uses up, so the overlay source can advance.

Each layer is configured with four values:
- a window, given as a start column, start row, width and height;
- a two-bit blend mode;
- an 8-bit static alpha;
- the width of the base frame.

Every colour plane is weighted by the same alpha and blended separately. In per-pixel mode the alpha comes from an extra plane carried above the colour planes. If an overlay would run past the right edge of the frame, it is still consumed but is not drawn. In that case an error flag travels with every output pixel.

Top module: `layer_blend_stage`

## Requirements
- R1: A background pixel outside the overlay window leaves the stage unchanged, and `ov_take_o` is low for it.
- R2: Mode 2'b01 (opaque) puts the overlay colour planes in place of the background planes for every pixel inside the window. The alpha plane is ignored in this mode.
- R3: Mode 2'b10 (static) weights each in-window pixel by `static_alpha_i`. With a = alpha and w = a + (a >> 7), the result is `out = (w*fg + (256-w)*bg + 128) >> 8`.
- R4: Mode 2'b11 (per pixel) uses the same formula as R3. The alpha is taken from the top 8 bits of plane 3 of `ov_pix_i` (bits 31:24), and `static_alpha_i` has no effect.
- R5: An alpha of 0 returns the background value exactly. An alpha of 255 returns the overlay value exactly.
- R6: Mode 2'b00 (disabled) passes every pixel through unchanged, holds `ov_take_o` low and holds `err_o` low.
- R7: When the mode is not disabled and `ov_x_i + ov_w_i > frame_w_i`, in-window pixels are not drawn (the background passes) and `ov_take_o` still goes high for them. `err_o` is 1 with each output pixel. An overlay that ends exactly at the frame edge is drawn and gives `err_o` = 0.
- R8: `pix_o`, `valid_o`, `x_o`, `y_o` and `err_o` appear 3 clock edges after the background pixel is sampled. A single valid input cycle gives a single valid output cycle.
- R9: Colour plane p sits at bits [8p+7:8p]. Every plane is blended on its own, using the shared alpha.
- R10: After reset, `valid_o`, `pix_o`, `x_o`, `y_o` and `err_o` are all 0.
- R11: A pixel is inside the window when `ov_x_i <= x < ov_x_i+ov_w_i` and `ov_y_i <= y < ov_y_i+ov_h_i`. The start edges count as inside and the end edges do not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_w_i | input | 12 | Base frame width in pixels |
| mode_i | input | 2 | Blend mode: 00 off, 01 opaque, 10 static, 11 per pixel |
| static_alpha_i | input | 8 | Register alpha |
| ov_x_i | input | 12 | Window start column |
| ov_y_i | input | 12 | Window start row |
| ov_w_i | input | 12 | Window width |
| ov_h_i | input | 12 | Window height |
| bg_valid_i | input | 1 | Background pixel valid |
| bg_x_i | input | 12 | Background pixel column |
| bg_y_i | input | 12 | Background pixel row |
| bg_pix_i | input | 24 | Background pixel, 3 planes |
| ov_pix_i | input | 32 | Overlay pixel, 3 colour planes plus alpha plane |
| ov_take_o | output | 1 | Overlay pixel consumed this cycle |
| valid_o | output | 1 | Output pixel valid |
| x_o | output | 12 | Output pixel column |
| y_o | output | 12 | Output pixel row |
| pix_o | output | 24 | Blended pixel |
| err_o | output | 1 | Overlay exceeds frame width |

## Verification
The bench probes the first and last column and row of the window, together with the pixel just outside each edge. An off-by-one compare would draw one column or row too many, or leave out the last one.

Alpha values of 0 and 255 are driven in both static and per-pixel mode. A design without the weight correction would fall one code short of the overlay value at full scale. A design that read the wrong alpha source would give a different mid-scale result.

Two overflow cases are covered: an overlay that ends exactly at the frame edge, and one that runs one column past it. A faulty design would either flag the legal layer or draw the illegal one.

The bench also checks that a disabled layer neither consumes data nor flags an error. It checks that a lone valid pulse comes out on exactly the third edge, carrying its position with it.

// File: rtl/blend_mix_pkg.sv
package blend_mix_pkg;
  typedef enum logic [1:0] {
    BM_OFF    = 2'b00,
    BM_OPAQUE = 2'b01,
    BM_CONST  = 2'b10,
    BM_PIXEL  = 2'b11
  } blend_mode_e;
endpackage

// File: rtl/mix_window.sv
module mix_window #(
  parameter int COORD_W = 12
) (
  input  logic [COORD_W-1:0] x_i,
  input  logic [COORD_W-1:0] y_i,
  input  logic [COORD_W-1:0] ov_x_i,
  input  logic [COORD_W-1:0] ov_y_i,
  input  logic [COORD_W-1:0] ov_w_i,
  input  logic [COORD_W-1:0] ov_h_i,
  input  logic [COORD_W-1:0] frame_w_i,
  output logic               hit_o,
  output logic               overflow_o
);
  logic [COORD_W:0] x_end, y_end;
  logic             in_x, in_y;

  always_comb begin
    x_end      = {1'b0, ov_x_i} + {1'b0, ov_w_i};
    y_end      = {1'b0, ov_y_i} + {1'b0, ov_h_i};
    in_x       = (x_i >= ov_x_i) && ({1'b0, x_i} < x_end);
    in_y       = (y_i >= ov_y_i) && ({1'b0, y_i} < y_end);
    hit_o      = in_x && in_y;
    overflow_o = x_end > {1'b0, frame_w_i};
  end
endmodule

// File: rtl/mix_alpha_sel.sv
module mix_alpha_sel
  import blend_mix_pkg::*;
#(
  parameter int ALPHA_W = 8
) (
  input  blend_mode_e        mode_i,
  input  logic               valid_i,
  input  logic               hit_i,
  input  logic               overflow_i,
  input  logic [ALPHA_W-1:0] static_alpha_i,
  input  logic [ALPHA_W-1:0] pix_alpha_i,
  output logic [ALPHA_W:0]   weight_o,
  output logic               take_o
);
  localparam logic [ALPHA_W:0] FULL = {1'b1, {ALPHA_W{1'b0}}};

  // map 0..2^N-1 onto 0..2^N so that full scale is exact
  function automatic logic [ALPHA_W:0] expand(input logic [ALPHA_W-1:0] a);
    return {1'b0, a} + {{ALPHA_W{1'b0}}, a[ALPHA_W-1]};
  endfunction

  always_comb begin
    take_o   = valid_i && hit_i && (mode_i != BM_OFF);
    weight_o = '0;
    if (take_o && !overflow_i) begin
      unique case (mode_i)
        BM_OPAQUE: weight_o = FULL;
        BM_CONST:  weight_o = expand(static_alpha_i);
        BM_PIXEL:  weight_o = expand(pix_alpha_i);
        default:   weight_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/mix_plane_blend.sv
module mix_plane_blend #(
  parameter int PIX_W   = 8,
  parameter int ALPHA_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ALPHA_W:0]   w_i,
  input  logic [PIX_W-1:0]   fg_i,
  input  logic [PIX_W-1:0]   bg_i,
  output logic [PIX_W-1:0]   pix_o
);
  localparam int               SW   = PIX_W + ALPHA_W + 2;
  localparam logic [ALPHA_W:0] FULL = {1'b1, {ALPHA_W{1'b0}}};
  localparam logic [SW-1:0]    HALF = SW'(1) << (ALPHA_W - 1);
  localparam logic [PIX_W-1:0] MAXP = {PIX_W{1'b1}};

  logic [SW-1:0]    sum_d, sum_q, shifted;
  logic [PIX_W-1:0] pix_d;

  always_comb begin
    sum_d   = SW'(w_i) * SW'(fg_i) + SW'(FULL - w_i) * SW'(bg_i) + HALF;
    shifted = sum_q >> ALPHA_W;
    pix_d   = (shifted > SW'(MAXP)) ? MAXP : shifted[PIX_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      pix_o <= '0;
    end else begin
      sum_q <= sum_d;
      pix_o <= pix_d;
    end
  end

  AST_ZERO_ALPHA_BG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_i == '0) |-> ##2 (pix_o == $past(bg_i, 2))); // R5
  AST_FULL_ALPHA_FG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (w_i == FULL) |-> ##2 (pix_o == $past(fg_i, 2))); // R5
endmodule

// File: rtl/layer_blend_stage.sv
module layer_blend_stage
  import blend_mix_pkg::*;
#(
  parameter int PIX_W   = 8,
  parameter int PLANES  = 3,
  parameter int ALPHA_W = 8,
  parameter int COORD_W = 12
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [COORD_W-1:0]           frame_w_i,
  input  logic [1:0]                   mode_i,
  input  logic [ALPHA_W-1:0]           static_alpha_i,
  input  logic [COORD_W-1:0]           ov_x_i,
  input  logic [COORD_W-1:0]           ov_y_i,
  input  logic [COORD_W-1:0]           ov_w_i,
  input  logic [COORD_W-1:0]           ov_h_i,
  input  logic                         bg_valid_i,
  input  logic [COORD_W-1:0]           bg_x_i,
  input  logic [COORD_W-1:0]           bg_y_i,
  input  logic [PLANES*PIX_W-1:0]      bg_pix_i,
  input  logic [(PLANES+1)*PIX_W-1:0]  ov_pix_i,
  output logic                         ov_take_o,
  output logic                         valid_o,
  output logic [COORD_W-1:0]           x_o,
  output logic [COORD_W-1:0]           y_o,
  output logic [PLANES*PIX_W-1:0]      pix_o,
  output logic                         err_o
);
  localparam int CW = PLANES * PIX_W;
  localparam int OW = (PLANES + 1) * PIX_W;

  blend_mode_e mode;
  logic        hit, ovf, err_d;
  logic [ALPHA_W:0] weight;

  assign mode  = blend_mode_e'(mode_i);
  assign err_d = bg_valid_i && (mode != BM_OFF) && ovf;

  mix_window #(.COORD_W(COORD_W)) u_win (
    .x_i        (bg_x_i),
    .y_i        (bg_y_i),
    .ov_x_i     (ov_x_i),
    .ov_y_i     (ov_y_i),
    .ov_w_i     (ov_w_i),
    .ov_h_i     (ov_h_i),
    .frame_w_i  (frame_w_i),
    .hit_o      (hit),
    .overflow_o (ovf)
  );

  mix_alpha_sel #(.ALPHA_W(ALPHA_W)) u_alpha (
    .mode_i         (mode),
    .valid_i        (bg_valid_i),
    .hit_i          (hit),
    .overflow_i     (ovf),
    .static_alpha_i (static_alpha_i),
    .pix_alpha_i    (ov_pix_i[OW-1 -: ALPHA_W]),
    .weight_o       (weight),
    .take_o         (ov_take_o)
  );

  // stage 1: operands; stages 2-3 inside the plane blenders
  logic [ALPHA_W:0]     s1_w;
  logic [CW-1:0]        s1_fg, s1_bg;
  logic [2:0]           vld_q, err_q;
  logic [COORD_W-1:0]   xq [3];
  logic [COORD_W-1:0]   yq [3];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_w  <= '0;
      s1_fg <= '0;
      s1_bg <= '0;
      vld_q <= '0;
      err_q <= '0;
      for (int i = 0; i < 3; i++) begin
        xq[i] <= '0;
        yq[i] <= '0;
      end
    end else begin
      s1_w  <= weight;
      s1_fg <= ov_pix_i[CW-1:0];
      s1_bg <= bg_pix_i;
      vld_q <= {vld_q[1:0], bg_valid_i};
      err_q <= {err_q[1:0], err_d};
      xq[0] <= bg_x_i;
      yq[0] <= bg_y_i;
      for (int i = 1; i < 3; i++) begin
        xq[i] <= xq[i-1];
        yq[i] <= yq[i-1];
      end
    end
  end

  for (genvar p = 0; p < PLANES; p++) begin : g_plane
    mix_plane_blend #(.PIX_W(PIX_W), .ALPHA_W(ALPHA_W)) u_blend (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .w_i    (s1_w),
      .fg_i   (s1_fg[p*PIX_W +: PIX_W]),
      .bg_i   (s1_bg[p*PIX_W +: PIX_W]),
      .pix_o  (pix_o[p*PIX_W +: PIX_W])
    );
  end

  assign valid_o = vld_q[2];
  assign err_o   = err_q[2];
  assign x_o     = xq[2];
  assign y_o     = yq[2];

  AST_OVF_NOT_DRAWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bg_valid_i && ovf) |=> (s1_w == '0)); // R7
  AST_OFF_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode == BM_OFF) |-> !ov_take_o); // R6
  AST_OUTSIDE_NO_TAKE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit |-> !ov_take_o); // R1
  AST_VALID_LAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(bg_valid_i, 3)); // R8
endmodule

// File: tb/sim_layer_blend_stage.sv
module sim_layer_blend_stage;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0, rst_n = 0;
  logic [11:0] frame_w, ov_x, ov_y, ov_w, ov_h, bg_x, bg_y, x_o, y_o;
  logic [1:0]  mode;
  logic [7:0]  salpha;
  logic        bg_valid, take, valid_o, err_o;
  logic [23:0] bg_pix, pix_o;
  logic [31:0] ov_pix;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  layer_blend_stage u0 (
    .clk_i(clk), .rst_ni(rst_n), .frame_w_i(frame_w), .mode_i(mode),
    .static_alpha_i(salpha), .ov_x_i(ov_x), .ov_y_i(ov_y), .ov_w_i(ov_w),
    .ov_h_i(ov_h), .bg_valid_i(bg_valid), .bg_x_i(bg_x), .bg_y_i(bg_y),
    .bg_pix_i(bg_pix), .ov_pix_i(ov_pix), .ov_take_o(take), .valid_o(valid_o),
    .x_o(x_o), .y_o(y_o), .pix_o(pix_o), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_pl(input int a, input int fg, input int bg);
    int w;
    w = a + (a >> 7);
    return 8'((w*fg + (256-w)*bg + 128) >> 8);
  endfunction

  function automatic logic [23:0] ref_px(input int a, input logic [23:0] fg, input logic [23:0] bg);
    logic [23:0] r;
    for (int p = 0; p < 3; p++) r[p*8 +: 8] = ref_pl(a, fg[p*8 +: 8], bg[p*8 +: 8]);
    return r;
  endfunction

  task automatic cfg(input logic [1:0] m, input logic [7:0] a, input int x0, input int w);
    mode = m; salpha = a; ov_x = 12'(x0); ov_w = 12'(w);
  endtask

  // one isolated pixel; output sampled after the third edge
  task automatic px(input string tag, input int x, input int y, input logic [23:0] bg,
                    input logic [31:0] ov, input logic [23:0] exp, input logic exp_take,
                    input logic exp_err);
    @(negedge clk);
    bg_valid = 1; bg_x = 12'(x); bg_y = 12'(y); bg_pix = bg; ov_pix = ov;
    #1 check({tag, " take"}, {31'b0, take}, {31'b0, exp_take});
    @(posedge clk); @(negedge clk);
    bg_valid = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check({tag, " pix"}, {8'b0, pix_o}, {8'b0, exp});
    check({tag, " err"}, {31'b0, err_o}, {31'b0, exp_err});
    check({tag, " pos"}, {8'b0, x_o, y_o}, {8'b0, 12'(x), 12'(y)});
  endtask

  localparam logic [23:0] BG = 24'h32_64_FF;
  localparam logic [23:0] FG = 24'h00_C8_64;

  task automatic t_reset;
    check("R10 valid", {31'b0, valid_o}, 0);
    check("R10 pix", {8'b0, pix_o}, 0);
    check("R10 err", {31'b0, err_o}, 0);
    check("R10 pos", {8'b0, x_o, y_o}, 0);
  endtask

  task automatic t_window;
    cfg(2'b01, 8'd0, 10, 10);
    px("R1 left", 9, 5, BG, {8'h00, FG}, BG, 0, 0);
    px("R1 right", 20, 5, BG, {8'h00, FG}, BG, 0, 0);
    px("R1 above", 12, 4, BG, {8'h00, FG}, BG, 0, 0);
    px("R1 below", 12, 9, BG, {8'h00, FG}, BG, 0, 0);
    px("R11 first", 10, 5, BG, {8'h00, FG}, FG, 1, 0);
    px("R11 last", 19, 8, BG, {8'h00, FG}, FG, 1, 0);
    px("R2 opaque", 15, 6, BG, {8'h00, FG}, FG, 1, 0);
  endtask

  task automatic t_static;
    cfg(2'b10, 8'd128, 10, 10);
    px("R3 mid", 11, 6, BG, {8'hFF, FG}, ref_px(128, FG, BG), 1, 0);
    px("R9 planes", 11, 6, 24'h10_80_F0, {8'h00, 24'hF0_80_10},
       ref_px(128, 24'hF0_80_10, 24'h10_80_F0), 1, 0);
    cfg(2'b10, 8'd0, 10, 10);
    px("R5 zero", 11, 6, BG, {8'hFF, FG}, BG, 1, 0);
    cfg(2'b10, 8'd255, 10, 10);
    px("R5 full", 11, 6, BG, {8'h00, 24'hFF_FF_FF}, 24'hFF_FF_FF, 1, 0);
  endtask

  task automatic t_pixel;
    cfg(2'b11, 8'd255, 10, 10);
    px("R4 alpha64", 13, 7, BG, {8'h40, FG}, ref_px(64, FG, BG), 1, 0);
    px("R4 alpha0", 13, 7, BG, {8'h00, FG}, BG, 1, 0);
    px("R4 alphaFF", 13, 7, BG, {8'hFF, FG}, FG, 1, 0);
  endtask

  task automatic t_off;
    cfg(2'b00, 8'd255, 10, 10);
    px("R6 off", 12, 6, BG, {8'hFF, FG}, BG, 0, 0);
  endtask

  task automatic t_overflow;
    cfg(2'b01, 8'd0, 54, 10);
    px("R7 fits", 54, 6, BG, {8'h00, FG}, FG, 1, 0);
    cfg(2'b01, 8'd0, 55, 10);
    px("R7 over", 55, 6, BG, {8'h00, FG}, BG, 1, 1);
    cfg(2'b00, 8'd0, 55, 10);
    px("R7 over off", 55, 6, BG, {8'h00, FG}, BG, 0, 0);
  endtask

  task automatic t_latency;
    cfg(2'b01, 8'd0, 10, 10);
    @(negedge clk);
    bg_valid = 1; bg_x = 12'd33; bg_y = 12'd2;
    @(posedge clk); @(negedge clk);
    bg_valid = 0;
    check("R8 edge1", {31'b0, valid_o}, 0);
    @(posedge clk); @(negedge clk);
    check("R8 edge2", {31'b0, valid_o}, 0);
    @(posedge clk); @(negedge clk);
    check("R8 edge3", {31'b0, valid_o}, 1);
    check("R8 pos", {8'b0, x_o, y_o}, {8'b0, 12'd33, 12'd2});
    @(posedge clk); @(negedge clk);
    check("R8 single", {31'b0, valid_o}, 0);
  endtask

  initial begin
    frame_w = 12'd64; ov_y = 12'd5; ov_h = 12'd4;
    mode = 0; salpha = 0; ov_x = 0; ov_w = 0;
    bg_valid = 0; bg_x = 0; bg_y = 0; bg_pix = 0; ov_pix = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_window();
    t_static();
    t_pixel();
    t_off();
    t_overflow();
    t_latency();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule